// File: doc/BRIEF.md
# Text Command Front End for a Word Memory

This block sits between a serial receiver and a small word memory. It watches a stream of received bytes, recognises two line-oriented text commands, checks their syntax and numeric ranges while the characters arrive, and then performs the requested memory access. It answers every command with a line of ASCII text on a byte output. That text says the store succeeded, gives the value read in decimal, or reports that the command was rejected.

A store command is `write:A,D` and a fetch command is `read:A`, each ended by carriage return (0x0D) then line feed (0x0A). A and D are unsigned decimal numbers. The memory port is synchronous: read data is expected on the cycle after the read enable. Two indicator outputs show whether the most recent command was accepted or rejected. Parsing continues while a reply is being sent. A command that completes during a reply has its reply sent as soon as the current one ends.

Top module: `ascii_ram_cmd`

## Requirements
- R1: A line `write:A,D` followed by 0x0D 0x0A, with A and D in range, stores D at A and produces exactly the 28 bytes `Write FPGA Ram Successfully!`, with no line ending.
- R2: A line `read:A` followed by 0x0D 0x0A, with A in range, produces `Read FPGA Ram:`, then the stored value in decimal with no leading zeros (a single `0` for zero), then 0x0D 0x0A.
- R3: An address above 255 or a data value above 65535 rejects the command, including digit strings far longer than the field. 255 and 65535 are accepted, and leading zeros are allowed.
- R4: The command word is matched without regard to letter case and must be exactly `write` or `read`. Any other word, including a longer or shorter one, is rejected.
- R5: A write with no comma after the address, a read with a comma, an empty number field, or any unexpected character makes the command invalid. An invalid command produces `Bad Command!` followed by 0x0D 0x0A.
- R6: A memory write or read is issued only in the single cycle after the accepted line feed of a fully valid line. A rejected line never changes memory.
- R7: After an invalid command `err_led`=1 and `ok_led`=0. After a valid command `ok_led`=1 and `err_led`=0. The two are never high together.
- R8: Once a line is found invalid, the following bytes are ignored until a 0x0D 0x0A pair ends that line. Each line produces exactly one reply.
- R9: Bytes that arrive while a reply is being sent are still parsed, and the next reply starts after the current one ends. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R10: After reset `tx_valid`, `mem_we`, `mem_re`, `ok_led` and `err_led` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte is available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Consumer takes the reply byte this cycle |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable (one cycle) |
| mem_re | output | 1 | Memory read enable (one cycle) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_re` |
| ok_led | output | 1 | Last command was accepted |
| err_led | output | 1 | Last command was rejected |

## Verification
The assertions check, on every cycle, the rules that hold at the ports:
- a memory access occurs only right after a received line feed, and read and write never coincide;
- a held reply byte stays stable;
- the two indicators are never high together;
- the outputs are clear after reset.

The content of the replies can only be shown by the bench's scenarios. The same holds for range and case handling, the fact that rejected lines leave memory untouched, and that bytes received during a long reply are not lost. These scenarios run directed boundary lines and random well-formed and out-of-range commands, and the bench checks each reply against a memory model of its own.

// File: rtl/acp_pkg.sv
// Shared types and character codes for the text command front end.
package acp_pkg;
    typedef enum logic [1:0] {
        RK_BAD   = 2'd0,
        RK_WRITE = 2'd1,
        RK_READ  = 2'd2
    } rkind_e;

    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_COMMA = 8'h2C;
    localparam logic [7:0] CH_ZERO  = 8'h30;
endpackage

// File: rtl/acp_dec_acc.sv
// Decimal accumulator: value = value*10 + digit per enabled cycle.
// Assumes digit is 0..9. Sets a sticky over flag once the value would
// exceed LIMIT and then holds the value, so any digit count is safe.
module acp_dec_acc #(
    parameter int unsigned LIMIT = 255
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            en,
    input  logic [3:0]                      digit,
    output logic [$clog2(LIMIT+1)-1:0]      value,
    output logic                            over
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W+3:0] nxt;

    // Candidate next value: 8v + 2v + digit, wide enough for no wrap.
    always_comb begin
        nxt = ({4'b0, value} << 3) + ({4'b0, value} << 1) + {{W{1'b0}}, digit};
    end

    // Accumulate or saturate into the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
            over  <= 1'b0;
        end else if (en) begin
            if (over || (nxt > (W+4)'(LIMIT))) begin
                over <= 1'b1;
            end else begin
                value <= nxt[W-1:0];
            end
        end
    end
endmodule

// File: rtl/acp_line_parser.sv
// Line parser: walks the received bytes through word, address, data and
// terminator phases. On the line feed that ends a line it pulses done for
// one cycle with ok/is_write; addr and data stay valid during that cycle.
// Assumes at most one byte per cycle on rx_valid.
module acp_line_parser import acp_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              done,
    output logic              ok,
    output logic              is_write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned A_LIMIT = (2 ** ADDR_W) - 1;
    localparam int unsigned D_LIMIT = (2 ** DATA_W) - 1;
    localparam logic [39:0] WORD_WR = "write";
    localparam logic [31:0] WORD_RD = "read";

    typedef enum logic [2:0] {
        P_WORD, P_ADDR, P_DATA, P_LF, P_SKIP, P_SKLF
    } pstate_e;

    pstate_e     st;
    logic [2:0]  wi;
    logic        mw, mr, have_d;
    logic [7:0]  lc;
    logic        is_alpha, is_dig, a_over, d_over;
    pstate_e     bad_st;

    // Lower-case fold and character classes of the current byte.
    always_comb begin
        lc       = (rx_data >= 8'h41 && rx_data <= 8'h5A) ? (rx_data | 8'h20) : rx_data;
        is_alpha = (lc >= 8'h61 && lc <= 8'h7A);
        is_dig   = (rx_data >= 8'h30 && rx_data <= 8'h39);
        bad_st   = (rx_data == CH_CR) ? P_SKLF : P_SKIP;
    end

    // True when the folded letter matches position i of the chosen word.
    function automatic logic word_hit(input logic wr, input logic [2:0] i, input logic [7:0] c);
        if (wr) return (i < 3'd5) && (WORD_WR[8*(4-int'(i)) +: 8] == c);
        return (i < 3'd4) && (WORD_RD[8*(3-int'(i)) +: 8] == c);
    endfunction

    acp_dec_acc #(.LIMIT(A_LIMIT)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(st == P_WORD),
        .en(rx_valid && st == P_ADDR && is_dig), .digit(rx_data[3:0]),
        .value(addr), .over(a_over)
    );

    acp_dec_acc #(.LIMIT(D_LIMIT)) u_data (
        .clk(clk), .rst_n(rst_n), .clr(st == P_WORD),
        .en(rx_valid && st == P_DATA && is_dig), .digit(rx_data[3:0]),
        .value(data), .over(d_over)
    );

    // Phase machine: one transition per received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= P_WORD;
            wi       <= '0;
            mw       <= 1'b1;
            mr       <= 1'b1;
            have_d   <= 1'b0;
            is_write <= 1'b0;
            done     <= 1'b0;
            ok       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rx_valid) begin
                case (st)
                    P_WORD: begin
                        if (rx_data == CH_COLON) begin
                            have_d <= 1'b0;
                            if (mw && wi == 3'd5) begin
                                is_write <= 1'b1;
                                st       <= P_ADDR;
                            end else if (mr && wi == 3'd4) begin
                                is_write <= 1'b0;
                                st       <= P_ADDR;
                            end else begin
                                st <= P_SKIP;
                            end
                        end else if (is_alpha) begin
                            mw <= mw && word_hit(1'b1, wi, lc);
                            mr <= mr && word_hit(1'b0, wi, lc);
                            if (wi != 3'd7) wi <= wi + 3'd1;
                        end else begin
                            st <= bad_st;
                        end
                    end
                    P_ADDR: begin
                        if (is_dig) begin
                            have_d <= 1'b1;
                        end else if (rx_data == CH_COMMA && is_write && have_d) begin
                            have_d <= 1'b0;
                            st     <= P_DATA;
                        end else if (rx_data == CH_CR && !is_write && have_d) begin
                            st <= P_LF;
                        end else begin
                            st <= bad_st;
                        end
                    end
                    P_DATA: begin
                        if (is_dig) begin
                            have_d <= 1'b1;
                        end else if (rx_data == CH_CR && have_d) begin
                            st <= P_LF;
                        end else begin
                            st <= bad_st;
                        end
                    end
                    P_LF: begin
                        if (rx_data == CH_LF) begin
                            done <= 1'b1;
                            ok   <= !a_over && !(is_write && d_over);
                            st   <= P_WORD;
                            wi   <= '0;
                            mw   <= 1'b1;
                            mr   <= 1'b1;
                        end else begin
                            st <= bad_st;
                        end
                    end
                    P_SKIP: begin
                        if (rx_data == CH_CR) st <= P_SKLF;
                    end
                    P_SKLF: begin
                        if (rx_data == CH_LF) begin
                            done <= 1'b1;
                            ok   <= 1'b0;
                            st   <= P_WORD;
                            wi   <= '0;
                            mw   <= 1'b1;
                            mr   <= 1'b1;
                        end else if (rx_data != CH_CR) begin
                            st <= P_SKIP;
                        end
                    end
                    default: st <= P_SKIP;
                endcase
            end
        end
    end
endmodule

// File: rtl/acp_reply_tx.sv
// Reply generator: one pending slot plus a byte sequencer. A pushed
// result waits in the slot until the current reply ends, then its text
// is streamed on a valid/ready port. Read values are converted to
// decimal once at load time with shift-and-add-3.
// Assumes at most one push arrives while a reply is in flight.
module acp_reply_tx import acp_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  rkind_e            push_kind,
    input  logic [DATA_W-1:0] push_val,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);
    localparam int DIG     = (DATA_W * 30103) / 100000 + 1;
    localparam int BCD_W   = 4 * DIG;
    localparam int PRE_LEN = 14;
    localparam int WR_LEN  = 28;
    localparam int BAD_LEN = 14;
    localparam logic [8*PRE_LEN-1:0] S_PRE = "Read FPGA Ram:";
    localparam logic [8*WR_LEN-1:0]  S_WR  = "Write FPGA Ram Successfully!";
    localparam logic [8*BAD_LEN-1:0] S_BAD = "Bad Command!\015\012";

    logic              pend_v, busy, load;
    rkind_e            pend_kind, kind;
    logic [DATA_W-1:0] pend_val;
    logic [5:0]        idx, last_idx;
    logic [BCD_W-1:0]  bcd, bcd_new;
    logic [3:0]        nd;
    logic [7:0]        ch;
    int                j, k;

    // Binary to packed decimal digits.
    function automatic logic [BCD_W-1:0] to_bcd(input logic [DATA_W-1:0] v);
        logic [BCD_W-1:0] b;
        b = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIG; d++) begin
                if (b[4*d +: 4] >= 4'd5) b[4*d +: 4] = b[4*d +: 4] + 4'd3;
            end
            b = {b[BCD_W-2:0], v[i]};
        end
        return b;
    endfunction

    // Number of significant digits, at least one.
    function automatic logic [3:0] digit_count(input logic [BCD_W-1:0] b);
        logic [3:0] n;
        n = 4'd1;
        for (int d = 1; d < DIG; d++) begin
            if (b[4*d +: 4] != 4'd0) n = 4'(d + 1);
        end
        return n;
    endfunction

    assign load     = !busy && pend_v;
    assign bcd_new  = to_bcd(pend_val);
    assign tx_valid = busy;
    assign tx_data  = ch;

    // Index of the final byte of the current reply.
    always_comb begin
        case (kind)
            RK_BAD:   last_idx = 6'(BAD_LEN - 1);
            RK_WRITE: last_idx = 6'(WR_LEN - 1);
            default:  last_idx = 6'(PRE_LEN + 1) + {2'b00, nd};
        endcase
    end

    // Byte at the current index of the current reply.
    always_comb begin
        j  = int'(idx);
        k  = j - PRE_LEN;
        ch = 8'h00;
        case (kind)
            RK_BAD:   ch = S_BAD[8*(BAD_LEN-1-j) +: 8];
            RK_WRITE: ch = S_WR[8*(WR_LEN-1-j) +: 8];
            default: begin
                if (j < PRE_LEN)          ch = S_PRE[8*(PRE_LEN-1-j) +: 8];
                else if (k < int'(nd))    ch = CH_ZERO | {4'h0, bcd[4*(int'(nd)-1-k) +: 4]};
                else if (k == int'(nd))   ch = CH_CR;
                else                      ch = CH_LF;
            end
        endcase
    end

    // Pending slot: filled by push, emptied by load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_kind <= RK_BAD;
            pend_val  <= '0;
        end else begin
            if (load) pend_v <= 1'b0;
            if (push) begin
                pend_v    <= 1'b1;
                pend_kind <= push_kind;
                pend_val  <= push_val;
            end
        end
    end

    // Sequencer: load a reply, advance on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            kind <= RK_BAD;
            bcd  <= '0;
            nd   <= 4'd1;
        end else if (load) begin
            busy <= 1'b1;
            idx  <= '0;
            kind <= pend_kind;
            bcd  <= bcd_new;
            nd   <= digit_count(bcd_new);
        end else if (busy && tx_ready) begin
            if (idx == last_idx) busy <= 1'b0;
            else                 idx  <= idx + 6'd1;
        end
    end
endmodule

// File: rtl/ascii_ram_cmd.sv
// Top: text command front end for a synchronous word memory. The parser
// decides each line; a valid line drives one memory access cycle, the
// outcome (with read data one cycle later) goes to the reply generator,
// and the indicators latch the verdict. Memory read latency is one cycle.
module ascii_ram_cmd import acp_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ok_led,
    output logic              err_led
);
    logic              p_done, p_ok, p_wr;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;
    logic              cap_v;
    rkind_e            cap_kind;

    acp_line_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .done(p_done), .ok(p_ok), .is_write(p_wr), .addr(p_addr), .data(p_data)
    );

    assign mem_we    = p_done && p_ok && p_wr;
    assign mem_re    = p_done && p_ok && !p_wr;
    assign mem_addr  = p_addr;
    assign mem_wdata = p_data;

    // Stage the verdict one cycle so read data lines up with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v    <= 1'b0;
            cap_kind <= RK_BAD;
        end else begin
            cap_v    <= p_done;
            cap_kind <= !p_ok ? RK_BAD : (p_wr ? RK_WRITE : RK_READ);
        end
    end

    // Indicators follow the verdict of each finished line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_led  <= 1'b0;
            err_led <= 1'b0;
        end else if (p_done) begin
            ok_led  <= p_ok;
            err_led <= !p_ok;
        end
    end

    acp_reply_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .push(cap_v), .push_kind(cap_kind),
        .push_val(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );
endmodule

// File: rtl/acp_checker.sv
// Port-level properties of the text command front end, bound to the top.
module acp_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [7:0]        rx_data,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              mem_re,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              ok_led,
    input logic              err_led
);
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_access_after_lf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $past(rx_valid && rx_data == 8'h0A));

    p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    p_access_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> !(mem_we || mem_re));

    p_led_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_led, err_led}));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tx_valid && !mem_we && !mem_re && !ok_led && !err_led));
endmodule

bind ascii_ram_cmd acp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .ok_led(ok_led), .err_led(err_led)
);

// File: tb/tb_ascii_ram_cmd.sv
// Bench: directed corner lines plus seeded random commands; replies are
// compared with text built from a bench-side memory model.
module tb_ascii_ram_cmd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we, mem_re;
    logic [15:0] mem_rdata = 16'h0;
    logic        ok_led, err_led;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ready_pct = 70;
    logic [15:0] bram  [256];
    logic [15:0] model [256];
    byte  rxq[$];
    string crlf, wr_ok, bad;

    always #10 clk = ~clk;

    ascii_ram_cmd dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .ok_led(ok_led), .err_led(err_led)
    );

    // Environment memory with one cycle read latency.
    always @(posedge clk) begin
        if (mem_we) bram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= bram[mem_addr];
    end

    // Reply sink: choose ready away from the edge and record accepted bytes.
    always @(negedge clk) begin
        bit r;
        r = (($urandom % 100) < ready_pct);
        if (r && tx_valid) rxq.push_back(tx_data);
        tx_ready = r;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit cond, input string tag, input string msg);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic send_byte(input byte b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic send_raw(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    function automatic string rd_reply(input int v);
        return $sformatf("Read FPGA Ram:%0d%s", v, crlf);
    endfunction

    task automatic expect_reply(input string exp, input string tag);
        int t;
        bit same;
        string got;
        t = 0;
        while (rxq.size() < exp.len() && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (40) @(negedge clk);
        same = (rxq.size() == exp.len());
        got = "";
        for (int i = 0; i < rxq.size(); i++) begin
            got = $sformatf("%s%c", got, rxq[i]);
            if (same && rxq[i] != exp[i]) same = 1'b0;
        end
        chk(same, tag, $sformatf("reply actual \"%s\" (%0d bytes), expected \"%s\" (%0d bytes)",
            got, rxq.size(), exp, exp.len()));
        rxq.delete();
    endtask

    task automatic check_leds(input bit good, input string tag);
        chk(ok_led == good && err_led == !good, tag,
            $sformatf("leds actual ok=%0b err=%0b, expected ok=%0b err=%0b",
                ok_led, err_led, good, !good));
    endtask

    task automatic cmd(input string body, input string exp, input bit good, input string tag);
        send_raw({body, crlf});
        expect_reply(exp, tag);
        check_leds(good, tag);
    endtask

    function automatic string mix_case(input string w);
        string s;
        s = "";
        for (int i = 0; i < w.len(); i++) begin
            byte c;
            c = w[i];
            if ($urandom % 2) c = c - 8'd32;
            s = $sformatf("%s%c", s, c);
        end
        return s;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        crlf  = $sformatf("%c%c", 8'd13, 8'd10);
        wr_ok = "Write FPGA Ram Successfully!";
        bad   = {"Bad Command!", crlf};
        for (int i = 0; i < 256; i++) begin
            bram[i]  = 16'h0;
            model[i] = 16'h0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !mem_we && !mem_re && !ok_led && !err_led, "R10",
            $sformatf("after reset actual tx_valid=%0b we=%0b re=%0b ok=%0b err=%0b, expected all 0",
                tx_valid, mem_we, mem_re, ok_led, err_led));

        // Basic store and fetch.
        cmd("write:10,1234", wr_ok, 1'b1, "R1"); model[10] = 16'd1234;
        cmd("read:10", rd_reply(1234), 1'b1, "R2");
        cmd("read:0", rd_reply(0), 1'b1, "R2 zero value");

        // Range limits.
        cmd("write:255,65535", wr_ok, 1'b1, "R3 max"); model[255] = 16'hFFFF;
        cmd("read:0000000000000000255", rd_reply(65535), 1'b1, "R3 leading zeros");
        cmd("write:256,1", bad, 1'b0, "R3 addr over");
        cmd("write:5,65536", bad, 1'b0, "R3 data over");
        cmd("write:99999999999999999999,7", bad, 1'b0, "R3 long digits");
        cmd("read:5", rd_reply(0), 1'b1, "R6 rejected writes left memory");

        // Case and word matching.
        cmd("WrItE:20,42", wr_ok, 1'b1, "R4 mixed case"); model[20] = 16'd42;
        cmd("READ:20", rd_reply(42), 1'b1, "R4 upper case");
        cmd("writes:20,1", bad, 1'b0, "R4 long word");
        cmd("rea:20", bad, 1'b0, "R4 short word");
        cmd("hello", bad, 1'b0, "R5 no colon");

        // Syntax errors.
        cmd("write:30", bad, 1'b0, "R5 no comma");
        cmd("read:30,1", bad, 1'b0, "R5 read comma");
        cmd("write:,5", bad, 1'b0, "R5 empty addr");
        cmd("write:30,", bad, 1'b0, "R5 empty data");
        check_leds(1'b0, "R7 error leds");

        // Ignore until the line is closed.
        send_raw({"write:3,7", 8'd13, "X"});
        send_raw(crlf);
        expect_reply(bad, "R8 stray after CR");
        cmd("write:4,9x,write:4,8", bad, 1'b0, "R8 single reply");
        cmd("read:3", rd_reply(0), 1'b1, "R6 read 3 unchanged");
        cmd("read:4", rd_reply(0), 1'b1, "R6 read 4 unchanged");
        check_leds(1'b1, "R7 ok leds");

        // Command arriving during a slow reply.
        ready_pct = 15;
        send_raw({"write:40,777", crlf});
        send_raw({"read:40", crlf});
        expect_reply({wr_ok, rd_reply(777)}, "R9 back to back");
        model[40] = 16'd777;
        ready_pct = 70;

        // Seeded random mix.
        for (int n = 0; n < 60; n++) begin
            int op;
            int a;
            int d;
            op = $urandom % 5;
            a  = $urandom % 256;
            d  = $urandom % 65536;
            ready_pct = 30 + ($urandom % 71);
            case (op)
                0, 1: begin
                    cmd($sformatf("%s:%0d,%0d", mix_case("write"), a, d), wr_ok, 1'b1, "R1 random");
                    model[a] = 16'(d);
                end
                2, 3: cmd($sformatf("%s:%0d", mix_case("read"), a), rd_reply(int'(model[a])), 1'b1, "R2 random");
                default: cmd($sformatf("write:%0d,%0d", a, 65536 + d), bad, 1'b0, "R3 random over");
            endcase
        end
        ready_pct = 100;
        cmd("read:255", rd_reply(int'(model[255])), 1'b1, "R2 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule